// File: doc/BRIEF.md
# I2C Master SCL Clock Divider

This block produces the serial clock level that an I2C master drives, derived from the system clock (a 4 MHz reference in the intended system). A 5-bit divider code and a speed-select bit choose the bus rate. In normal-speed mode one SCL period lasts eight times the code in system clocks. In fast mode it lasts four times the code. Every setting gives a 50% duty cycle except one fast-mode code. That code gives 400 kHz, with SCL high for 4 clocks and low for 6.

Codes that are too small for the selected mode are refused. The block then leaves SCL released (high) and raises an error flag. Along with the level, the block gives one-cycle strobes on each rising and falling SCL transition, which the surrounding bus controller uses to shift data. Every period starts with a low phase. The divider settings are captured at the start of each period.

Top module: `scl_clk_div`

## Requirements
- R1: Out of reset, scl_o is 1 and rise_o, fall_o and err_o are 0.
- R2: In normal-speed mode (fast_i = 0) with a code c in 5..31, every SCL period has a low phase of 4*c clocks followed by a high phase of 4*c clocks.
- R3: In fast mode (fast_i = 1) with a code c in 3..4 or 6..31, every period has a low phase of 2*c clocks followed by a high phase of 2*c clocks.
- R4: In fast mode with code 5, every period has a low phase of 6 clocks and a high phase of 4 clocks.
- R5: A refused setting holds scl_o at 1 with no fall_o strobe, and err_o is 1 one clock after the setting is applied while enabled. The refused codes are 0..4 in normal-speed mode and 0..2 in fast mode. A refused setting applied while SCL runs stops it on the next clock.
- R6: err_o is 0 one clock after a valid setting is applied, and also whenever en_i is 0, regardless of the code.
- R7: When en_i drops, scl_o is 1 on the next clock. A low phase that is cut short this way is ended with a rise_o strobe, and no further strobes follow.
- R8: In the clock after en_i rises with a valid setting, scl_o goes to 0 with a fall_o strobe.
- R9: The code and mode are captured at each falling SCL edge. A change between two falling edges alters only the period that starts at the next falling edge.
- R10: rise_o is 1 exactly in the clock where scl_o goes from 0 to 1, and fall_o is 1 exactly in the clock where scl_o goes from 1 to 0. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable for the SCL generator |
| ccr_i | input | 5 | Divider code |
| fast_i | input | 1 | Speed select: 0 normal-speed, 1 fast |
| scl_o | output | 1 | SCL drive level (1 = released) |
| rise_o | output | 1 | One-clock strobe on each 0-to-1 SCL transition |
| fall_o | output | 1 | One-clock strobe on each 1-to-0 SCL transition |
| err_o | output | 1 | Refused divider setting while enabled |

## Verification
The bench measures every low and high phase and checks it against the mode formula. It covers the smallest legal code in each mode, the largest code, and the odd 6/4 split at fast code 5. A design that wrongly applied the half-period rule there would show 10/10 phases. A design with an off-by-one counter reload would miss every phase by a clock.

The codes just below each mode's minimum must keep SCL released and raise the flag. This catches a comparator that uses the wrong mode's limit. Two further cases probe the capture point and the shutdown path. A code changed mid-period must alter only the next period, so a design that samples the code live would stretch or shrink the current one. Disabling during a low phase must release SCL with a rise strobe in the very next clock.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    localparam int unsigned CCR_W = 5;
    localparam int unsigned LEN_W = CCR_W + 2;

    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        logic valid;
        len_t lo_len;
        len_t hi_len;
    } scl_cfg_t;

    typedef struct packed {
        logic run;
        logic scl;
        logic rise;
        logic fall;
        logic err;
        len_t hi_len;
    } scl_state_t;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
    import scl_div_pkg::*;
#(
    parameter int unsigned STD_MIN      = 5,
    parameter int unsigned FAST_MIN     = 3,
    parameter int unsigned STD_SHIFT    = 2,
    parameter int unsigned FAST_SHIFT   = 1,
    parameter bit          SPECIAL_EN   = 1'b1,
    parameter int unsigned SPECIAL_CODE = 5,
    parameter int unsigned SPECIAL_HI   = 4,
    parameter int unsigned SPECIAL_LO   = 6
) (
    input  logic [CCR_W-1:0] ccr,
    input  logic             fast,
    output scl_cfg_t         cfg
);
    len_t base;
    len_t half_len;
    logic special_hit;

    assign base = len_t'(ccr);

    generate
        if (SPECIAL_EN) begin : g_special
            assign special_hit = fast && (ccr == CCR_W'(SPECIAL_CODE));
        end else begin : g_no_special
            assign special_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        half_len   = fast ? (base << FAST_SHIFT) : (base << STD_SHIFT);
        cfg.valid  = fast ? (ccr >= CCR_W'(FAST_MIN)) : (ccr >= CCR_W'(STD_MIN));
        cfg.lo_len = special_hit ? len_t'(SPECIAL_LO) : half_len;
        cfg.hi_len = special_hit ? len_t'(SPECIAL_HI) : half_len;
    end

    // R2: a legal setting never yields an empty phase
    always_comb begin
        if (cfg.valid) begin
            a_len_nonzero_r2: assert (cfg.lo_len != '0 && cfg.hi_len != '0);
        end
    end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  len_t load_val,
    output logic done
);
    len_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - len_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // R2: a running phase shortens by exactly one clock per cycle
    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - len_t'(1)));

    // R3: an idle timer stays at zero until reloaded
    p_zero_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
    import scl_div_pkg::*;
#(
    parameter int unsigned STD_MIN      = 5,
    parameter int unsigned FAST_MIN     = 3,
    parameter int unsigned SPECIAL_CODE = 5,
    parameter int unsigned SPECIAL_HI   = 4,
    parameter int unsigned SPECIAL_LO   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CCR_W-1:0] ccr_i,
    input  logic             fast_i,
    output logic             scl_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             err_o
);
    scl_cfg_t   cfg;
    scl_state_t st_d, st_q;
    logic       tmr_load;
    len_t       tmr_val;
    logic       tmr_done;

    scl_cfg_decode #(
        .STD_MIN      (STD_MIN),
        .FAST_MIN     (FAST_MIN),
        .STD_SHIFT    (2),
        .FAST_SHIFT   (1),
        .SPECIAL_EN   (1'b1),
        .SPECIAL_CODE (SPECIAL_CODE),
        .SPECIAL_HI   (SPECIAL_HI),
        .SPECIAL_LO   (SPECIAL_LO)
    ) u_decode (
        .ccr  (ccr_i),
        .fast (fast_i),
        .cfg  (cfg)
    );

    scl_phase_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        st_d.err  = en_i && !cfg.valid;
        tmr_load  = 1'b0;
        tmr_val   = '0;

        if (!en_i || !cfg.valid) begin
            st_d.run  = 1'b0;
            st_d.scl  = 1'b1;
            st_d.rise = !st_q.scl;
        end else if (!st_q.run) begin
            st_d.run    = 1'b1;
            st_d.scl    = 1'b0;
            st_d.fall   = 1'b1;
            st_d.hi_len = cfg.hi_len;
            tmr_load    = 1'b1;
            tmr_val     = cfg.lo_len - len_t'(1);
        end else if (tmr_done) begin
            if (!st_q.scl) begin
                st_d.scl  = 1'b1;
                st_d.rise = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = st_q.hi_len - len_t'(1);
            end else begin
                st_d.scl    = 1'b0;
                st_d.fall   = 1'b1;
                st_d.hi_len = cfg.hi_len;
                tmr_load    = 1'b1;
                tmr_val     = cfg.lo_len - len_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, scl: 1'b1, rise: 1'b0, fall: 1'b0,
                      err: 1'b0, hi_len: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o  = st_q.scl;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;
    assign err_o  = st_q.err;

    // R10: strobes mark real transitions of the SCL level
    p_rise_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (scl_o && !$past(scl_o)));
    p_fall_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!scl_o && $past(scl_o)));
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));

    // R5: a refused setting keeps SCL released
    p_err_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (scl_o && !fall_o));

    // R7: dropping the enable releases SCL on the next clock
    p_disable_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (scl_o && !fall_o && !err_o));
endmodule

// File: tb/scl_clk_div_tb.sv
module scl_clk_div_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [4:0] ccr_i = 5'd0;
    logic       fast_i = 1'b0;
    logic       scl_o, rise_o, fall_o, err_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nfall = 0;

    int    q_lo[$];
    int    q_hi[$];
    string q_req[$];

    always #2.5 clk = ~clk;

    scl_clk_div u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .ccr_i  (ccr_i),
        .fast_i (fast_i),
        .scl_o  (scl_o),
        .rise_o (rise_o),
        .fall_o (fall_o),
        .err_o  (err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_lo(input int c, input bit f);
        if (f && c == 5) return 6;
        return f ? 2 * c : 4 * c;
    endfunction

    function automatic int exp_hi(input int c, input bit f);
        if (f && c == 5) return 4;
        return f ? 2 * c : 4 * c;
    endfunction

    // scoreboard monitor: measures each complete low+high period
    int  fall_t = 0, rise_t = 0;
    bit  have_fall = 0, have_rise = 0;
    always @(negedge clk) begin
        cyc++;
        if (fall_o) nfall++;
        if (!en_i || err_o) begin
            have_fall = 0;
            have_rise = 0;
        end else begin
            if (rise_o && have_fall) begin
                rise_t = cyc;
                have_rise = 1;
            end
            if (fall_o) begin
                if (have_fall && have_rise) begin
                    if (q_lo.size() == 0) begin
                        check(0, "R2", "unexpected period", cyc - fall_t, 0);
                    end else begin
                        int el, eh;
                        string r;
                        el = q_lo.pop_front();
                        eh = q_hi.pop_front();
                        r  = q_req.pop_front();
                        check((rise_t - fall_t) == el, r, "low phase", rise_t - fall_t, el);
                        check((cyc - rise_t) == eh, r, "high phase", cyc - rise_t, eh);
                    end
                end
                fall_t = cyc;
                have_fall = 1;
                have_rise = 0;
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_falls(input int target);
        while (nfall < target) step();
    endtask

    task automatic run_cfg(input int c, input bit f, input int n, input string req);
        int start;
        ccr_i = 5'(c);
        fast_i = f;
        for (int i = 0; i < n; i++) begin
            q_lo.push_back(exp_lo(c, f));
            q_hi.push_back(exp_hi(c, f));
            q_req.push_back(req);
        end
        start = nfall;
        en_i = 1'b1;
        wait_falls(start + n + 1);
        en_i = 1'b0;
        step();
        step();
        check(q_lo.size() == 0, req, "periods left unchecked", q_lo.size(), 0);
    endtask

    task automatic check_refused(input int c, input bit f);
        int falls0;
        ccr_i = 5'(c);
        fast_i = f;
        en_i = 1'b1;
        falls0 = nfall;
        step();
        check(err_o == 1'b1, "R5", "err on refused code", err_o, 1);
        for (int i = 0; i < 40; i++) step();
        check(scl_o == 1'b1, "R5", "scl held high", scl_o, 1);
        check(nfall == falls0, "R5", "no fall strobes", nfall - falls0, 0);
        en_i = 1'b0;
        step();
        check(err_o == 1'b0, "R6", "err clears when disabled", err_o, 0);
    endtask

    initial begin
        repeat (3) step();
        // R1
        check(scl_o == 1'b1, "R1", "reset scl", scl_o, 1);
        check(rise_o == 1'b0 && fall_o == 1'b0, "R1", "reset strobes", rise_o | fall_o, 0);
        check(err_o == 1'b0, "R1", "reset err", err_o, 0);
        rst_n = 1'b1;
        step();

        // R6: refused code with enable low gives no error
        ccr_i = 5'd0;
        fast_i = 1'b0;
        step();
        check(err_o == 1'b0, "R6", "no err while disabled", err_o, 0);

        // R8: first edge latency
        ccr_i = 5'd5;
        en_i = 1'b1;
        step();
        check(scl_o == 1'b0 && fall_o == 1'b1, "R8", "first fall one clock after enable",
              {scl_o, fall_o}, 1);
        check(err_o == 1'b0, "R6", "no err on valid code", err_o, 0);
        // R7: disable during low phase
        en_i = 1'b0;
        step();
        check(scl_o == 1'b1 && rise_o == 1'b1, "R7", "release with rise", {scl_o, rise_o}, 3);
        step();
        check(rise_o == 1'b0 && fall_o == 1'b0 && scl_o == 1'b1, "R7", "quiet after release",
              {scl_o, rise_o, fall_o}, 4);
        repeat (3) step();

        // R2
        run_cfg(5, 1'b0, 3, "R2");
        run_cfg(9, 1'b0, 2, "R2");
        run_cfg(31, 1'b0, 2, "R2");
        // R3
        run_cfg(3, 1'b1, 3, "R3");
        run_cfg(4, 1'b1, 2, "R3");
        run_cfg(6, 1'b1, 2, "R3");
        run_cfg(31, 1'b1, 2, "R3");
        // R4
        run_cfg(5, 1'b1, 4, "R4");

        // R9: mid-period change affects only the next period
        begin
            int start;
            ccr_i = 5'd5;
            fast_i = 1'b0;
            q_lo.push_back(20); q_hi.push_back(20); q_req.push_back("R9");
            q_lo.push_back(24); q_hi.push_back(24); q_req.push_back("R9");
            start = nfall;
            en_i = 1'b1;
            wait_falls(start + 1);
            ccr_i = 5'd6;
            wait_falls(start + 3);
            en_i = 1'b0;
            step();
            step();
            check(q_lo.size() == 0, "R9", "periods left unchecked", q_lo.size(), 0);
        end

        // R5: refused codes
        check_refused(4, 1'b0);
        check_refused(0, 1'b0);
        check_refused(2, 1'b1);

        // R5: refused code applied while running stops SCL
        begin
            int start;
            ccr_i = 5'd3;
            fast_i = 1'b1;
            start = nfall;
            en_i = 1'b1;
            wait_falls(start + 1);
            ccr_i = 5'd2;
            step();
            check(scl_o == 1'b1 && rise_o == 1'b1, "R5", "running stop releases",
                  {scl_o, rise_o}, 3);
            check(err_o == 1'b1, "R5", "err after running stop", err_o, 1);
            en_i = 1'b0;
            step();
            check(err_o == 1'b0, "R6", "err drops with enable", err_o, 0);
        end

        // R10 strobes are otherwise covered by the period measurements
        check(scl_o == 1'b1, "R10", "final idle level", scl_o, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule